// File: doc/BRIEF.md
# Timestamp and Reloadable Event Timer

This block holds two timers behind a small register port. The first is a free-running timestamp counter. Software can sample it at any time, and any write to it restarts it from zero.

The second is a down-counting event timer. Its reload register carries two option bits in its low bits: an enable bit and a one-shot bit. The count value is the same register with those two bits forced to zero. In periodic mode the timer raises an event every N cycles, where N is the masked reload value. In one-shot mode it raises one event and then parks at zero.

Each event latches a pending flag in a status register, and software clears that flag by writing a one to it. The interrupt output is the level of the pending flag. Clock generation and prescaling are outside the block. It advances once per clock cycle.

Top module: `evt_timer_top`

## Requirements
- R1: After synchronous reset, the reload, count and status registers read 0 and `irq` is low. The first timestamp read after reset returns 0.
- R2: The timestamp (address 0) increments by one every cycle. A write of any value to address 0 makes it 0 on the next cycle, and it counts up from there.
- R3: A write to the reload register (address 1) stores the whole word, and address 1 reads it back unchanged. The same write loads the down counter (address 2) with the word's bits [1:0] forced to zero.
- R4: Reload bit 0 is the enable bit. While it is 0, or while the count is 0, the count holds its value.
- R5: With enable set, the count decrements by one per cycle. An expiry happens at the edge where the count leaves 1, so the pending flag rises exactly N clock edges after the write that loaded count N.
- R6: With reload bit 1 clear (periodic), an expiry reloads the count from the masked reload value, so the next expiry follows N edges later.
- R7: With reload bit 1 set (one-shot), an expiry sets the count to 0. No further expiry occurs until the reload register is written again.
- R8: Writing 0 to the reload register disables the timer and clears the count. No expiry follows.
- R9: Writing a word with bit 0 set to the status register (address 3) clears the pending flag. Writing a word with bit 0 clear leaves the flag unchanged. When an expiry and a clear fall in the same cycle, the flag stays set.
- R10: `reg_rdata` is registered. A read strobed at one edge presents, after that edge, the value the addressed register held before it. Status reads as {zeros, pending} at bit 0, and `irq` equals the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 timestamp, 1 reload, 2 count, 3 status |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Interrupt, level of the pending flag |

## Verification
The bench counts edges from each reload write to the rise of `irq`. A timer that expired when the count reached zero, instead of when it left one, would be late by one cycle. A timer that reloaded the unmasked word would show option bits in the count.

The bench issues a status clear on the exact edge of a periodic expiry. A design that gave the clear priority would drop that event. The bench also writes a clear with bit 0 low, and expects the flag to survive it.

After a one-shot expiry and after a zero write to the reload register, the bench watches for a long stretch. A design that kept counting would raise a second interrupt.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    A_STAMP  = 2'd0,
    A_RELOAD = 2'd1,
    A_COUNT  = 2'd2,
    A_STATUS = 2'd3
  } reg_addr_e;

  localparam int OPT_W       = 2;
  localparam int EN_BIT      = 0;
  localparam int ONESHOT_BIT = 1;
  localparam int PEND_BIT    = 0;
endpackage

// File: rtl/evt_ts_counter.sv
module evt_ts_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clr) value <= '0;
    else            value <= value + 1'b1;
  end
endmodule

// File: rtl/evt_down_timer.sv
module evt_down_timer
  import evt_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] count_q,
  output logic         expire
);
  localparam logic [W-1:0] CNT_MASK = {{(W-OPT_W){1'b1}}, {OPT_W{1'b0}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic enabled, oneshot;
  assign enabled = reload_q[EN_BIT];
  assign oneshot = reload_q[ONESHOT_BIT];

  // event when a running count leaves 1; a fresh load overrides it
  assign expire = enabled && (count_q == ONE) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      reload_q <= load_word;
      count_q  <= load_word & CNT_MASK;
    end else if (expire) begin
      count_q  <= oneshot ? '0 : (reload_q & CNT_MASK);
    end else if (enabled && count_q != '0) begin
      count_q  <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/evt_status.sv
module evt_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pend_q
);
  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)      pend_q <= 1'b0;
    else if (set) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic [CNT_W-1:0] ts_val, reload_val, count_val;
  logic             expire, pend;
  logic             wr_stamp, wr_reload, wr_clear;

  assign wr_stamp  = reg_wr && (reg_addr == A_STAMP);
  assign wr_reload = reg_wr && (reg_addr == A_RELOAD);
  assign wr_clear  = reg_wr && (reg_addr == A_STATUS) && reg_wdata[PEND_BIT];

  evt_ts_counter #(.W(CNT_W)) u_ts (
    .clk(clk), .rst(rst), .clr(wr_stamp), .value(ts_val)
  );

  evt_down_timer #(.W(CNT_W)) u_evt (
    .clk(clk), .rst(rst), .load(wr_reload), .load_word(reg_wdata),
    .reload_q(reload_val), .count_q(count_val), .expire(expire)
  );

  evt_status u_stat (
    .clk(clk), .rst(rst), .set(expire), .clr(wr_clear), .pend_q(pend)
  );

  assign irq = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STAMP:  reg_rdata <= ts_val;
        A_RELOAD: reg_rdata <= reload_val;
        A_COUNT:  reg_rdata <= count_val;
        default:  reg_rdata <= {{(CNT_W-1){1'b0}}, pend};
      endcase
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic         irq,
  input logic [W-1:0] ts,
  input logic [W-1:0] reload,
  input logic [W-1:0] count,
  input logic         expire
);
  logic wr_rel;
  assign wr_rel = reg_wr && reg_addr == 2'd1;

  assert_ts_step_R2: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 2'd0) |=> ts == $past(ts) + 1'b1);

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_rel && !reload[0]) |=> $stable(count));

  assert_expire_sets_R5: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq);

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && !reload[1]) |=> count == {$past(reload[W-1:2]), 2'b00});

  assert_oneshot_parks_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && reload[1]) |=> count == '0);

  assert_zero_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_rel && reg_wdata == '0) |=> (count == '0 && !reload[0]));

  assert_pend_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> irq);

  assert_status_read_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 2'd3) |=> reg_rdata == {{(W-1){1'b0}}, $past(irq)});
endmodule

bind evt_timer_top evt_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .ts(ts_val), .reload(reload_val), .count(count_val), .expire(expire)
);

// File: tb/sim_evt_timer_top.sv
module sim_evt_timer_top;
  localparam int W = 32;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;
  localparam int NV = 18;
  // {op, addr, data, expected}
  localparam logic [67:0] VEC [NV] = '{
    {OP_WR,   2'd0, 32'h0000DEAD, 32'h0},    // R2 restart timestamp
    {OP_RD,   2'd0, 32'h0,        32'h0},    // R2
    {OP_IDLE, 2'd0, 32'd5,        32'h0},
    {OP_RD,   2'd0, 32'h0,        32'd6},    // R2
    {OP_WR,   2'd1, 32'h00000102, 32'h0},    // R3 loaded, not enabled
    {OP_RD,   2'd1, 32'h0,        32'h102},  // R3
    {OP_RD,   2'd2, 32'h0,        32'h100},  // R3 masked
    {OP_IDLE, 2'd0, 32'd3,        32'h0},
    {OP_RD,   2'd2, 32'h0,        32'h100},  // R4 holds
    {OP_WR,   2'd1, 32'h00000047, 32'h0},
    {OP_RD,   2'd2, 32'h0,        32'h44},   // R3 masked
    {OP_RD,   2'd2, 32'h0,        32'h43},   // R5 decrement
    {OP_IDLE, 2'd0, 32'd2,        32'h0},
    {OP_RD,   2'd2, 32'h0,        32'h40},   // R5
    {OP_WR,   2'd1, 32'h0,        32'h0},    // R8
    {OP_RD,   2'd1, 32'h0,        32'h0},    // R8
    {OP_RD,   2'd2, 32'h0,        32'h0},    // R8
    {OP_RD,   2'd3, 32'h0,        32'h0}     // R10 no pending
  };

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer_top #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    rd(2'd0, r); check("R1 timestamp", r, 32'h0);
    rd(2'd1, r); check("R1 reload", r, 32'h0);
    rd(2'd2, r); check("R1 count", r, 32'h0);
    rd(2'd3, r); check("R1 status", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, a;
      logic [W-1:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        OP_WR:   wr(a, d);
        OP_RD:   begin rd(a, r); check($sformatf("R3/R4/R5/R8 vector %0d", i), r, e); end
        default: idle(int'(d));
      endcase
    end

    // R5 / R6 periodic, count 8
    wr(2'd1, 32'h9);
    idle(7);  check("R5 before expiry", {31'b0, irq}, 32'h0);
    idle(1);  check("R5 at expiry", {31'b0, irq}, 32'h1);
    rd(2'd3, r); check("R10 status read", r, 32'h1);
    wr(2'd3, 32'h2); check("R9 write without bit0", {31'b0, irq}, 32'h1);
    wr(2'd3, 32'h1); check("R9 clear", {31'b0, irq}, 32'h0);
    idle(4);  check("R6 before second expiry", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'h1); check("R9 set wins over clear / R6 period", {31'b0, irq}, 32'h1);
    rd(2'd2, r); check("R6 reloaded count", r, 32'h8);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h1); check("R9 clear after stop", {31'b0, irq}, 32'h0);

    // R7 one-shot, count 8
    wr(2'd1, 32'hB);
    idle(7);  check("R7 before expiry", {31'b0, irq}, 32'h0);
    idle(1);  check("R7 expiry", {31'b0, irq}, 32'h1);
    wr(2'd3, 32'h1);
    idle(30); check("R7 no second event", {31'b0, irq}, 32'h0);
    rd(2'd2, r); check("R7 count parked", r, 32'h0);

    // R8 zero write stops a running timer
    wr(2'd1, 32'h41);
    idle(3);
    wr(2'd1, 32'h0);
    idle(100); check("R8 no event after zero write", {31'b0, irq}, 32'h0);
    rd(2'd2, r); check("R8 count cleared", r, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule